// File: doc/BRIEF.md
# Banked Quad-Data-Rate SRAM Controller

This block connects a host to four burst-of-two quad-data-rate SRAM devices wired in depth expansion. All four devices share one address bus, one write-data bus and one read-data bus. Each device has its own active-low read and write port selects. The host issues a 2-bit command that can start a read, a write, or both at once. It supplies a 36-bit write word with four byte enables and receives assembled 36-bit read words with a ready flag.

The block runs on a single fast clock at twice the host transfer rate, and each fast cycle stands for one edge of the memory clock. A free-running phase bit splits the fast cycles into even and odd halves. The host command is sampled on even edges only, and the first fast edge after reset is an even edge. Writes and reads go through separate pipelines, so operations from consecutive host cycles overlap.

On the memory side, each 36-bit word travels as two 18-bit halves on consecutive fast cycles, lower half first. The two upper host-address bits choose the device, and the lower 18 bits go on the shared address bus.

Top module: `qdr_bank_ctl`

## Requirements
- R1: While reset is held and after it, all four read selects and all four write selects are high, and `rd_ready` is low.
- R2: The command is sampled on every second fast edge, beginning with the first fast edge after reset. Code 00 is idle: it lowers no select and raises no `rd_ready`. Selects only change on sampling edges.
- R3: For a write sampled at edge S (code 10 or 11), the chosen write select is low for exactly two fast cycles, starting at edge S+2. In the first of those cycles `sram_d` carries data bits [17:0] and `sram_bw_n` equals the inverse of byte enables [1:0]. In the second it carries bits [35:18] with the inverse of enables [3:2].
- R4: In the second write cycle (from edge S+3), `sram_addr` carries write-address bits [17:0].
- R5: For a read sampled at edge S (code 01 or 11), the chosen read select is low for two fast cycles starting at edge S+4. In the first of those cycles `sram_addr` carries read-address bits [17:0].
- R6: `sram_q` is captured at edge S+6 as the lower half and at edge S+7 as the upper half. From edge S+8, `rd_data` equals {upper, lower} and `rd_ready` is high for two fast cycles.
- R7: Address bits [19:18] give the index of the one select that goes low. At most one read select and at most one write select are low at any time.
- R8: Code 11 starts both a read and a write. Commands on every host cycle overlap without conflict, because write addresses use odd fast cycles and read addresses use even ones. A read reaches the bank after every write sampled in the same or an earlier host cycle, so a combined command to a single address returns the newly written word.
- R9: Byte enable j (j = 0..3) guards the 9-bit lane at bits [9j+8:9j]. A lane whose enable is clear keeps its previous contents, as seen by reading the word back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the host transfer rate |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | 00 idle, 01 read, 10 write, 11 read and write |
| rd_addr | input | 20 | Host read address; [19:18] pick the device |
| wr_addr | input | 20 | Host write address; [19:18] pick the device |
| wr_data | input | 36 | Host write word |
| wr_be | input | 4 | Byte enables, one per 9-bit lane |
| rd_data | output | 36 | Assembled read word |
| rd_ready | output | 1 | High while `rd_data` holds a fresh read word |
| sram_addr | output | 18 | Shared device address bus |
| sram_d | output | 18 | Shared write-data bus, one half per fast cycle |
| sram_bw_n | output | 2 | Active-low byte writes for the current half |
| sram_wps_n | output | 4 | Active-low write port selects, one per device |
| sram_rps_n | output | 4 | Active-low read port selects, one per device |
| sram_q | input | 18 | Shared read-data bus from the devices |

## Verification
Each result is due a fixed number of fast cycles after its sampling edge S:
- write selects, data halves and byte writes at S+2 and S+3, with the write address at S+3;
- read select and read address at S+4;
- returned halves consumed at S+6 and S+7;
- the host word and `rd_ready` at S+8 and S+9.

The bench numbers every fast edge from reset release. At each falling edge it derives, from that number, which host slot owns each bus, and compares against that slot's stimulus. A small device model in the bench writes and reads only what it sees on the buses. A slot-ordered reference memory computes each expected read word from the byte enables, so a wrong bank, address, half order or lane mask shows up in the returned data.

// File: rtl/qdr_ctl_pkg.sv
package qdr_ctl_pkg;

    localparam int HOST_AW = 20;
    localparam int HALF_W  = 18;
    localparam int BANKS   = 4;
    localparam int BW_HALF = 2;

    localparam int BANK_W  = $clog2(BANKS);
    localparam int DEV_AW  = HOST_AW - BANK_W;
    localparam int HOST_DW = 2 * HALF_W;
    localparam int BE_W    = 2 * BW_HALF;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_RD   = 2'b01,
        OP_WR   = 2'b10,
        OP_RW   = 2'b11
    } op_e;

    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
        logic [DEV_AW-1:0] addr;
    } rd_req_t;

    typedef struct packed {
        logic               vld;
        logic [BANK_W-1:0]  bank;
        logic [DEV_AW-1:0]  addr;
        logic [HOST_DW-1:0] data;
        logic [BE_W-1:0]    be;
    } wr_req_t;

    function automatic logic wants_rd(input logic [1:0] c);
        return (op_e'(c) == OP_RD) || (op_e'(c) == OP_RW);
    endfunction

    function automatic logic wants_wr(input logic [1:0] c);
        return (op_e'(c) == OP_WR) || (op_e'(c) == OP_RW);
    endfunction

    // Active-low one-cold select for the addressed device
    function automatic logic [BANKS-1:0] sel_n(input logic vld, input logic [BANK_W-1:0] b);
        logic [BANKS-1:0] s;
        s = '1;
        if (vld) s[b] = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/qdr_wr_seq.sv
module qdr_wr_seq
    import qdr_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ph,
    input  logic [1:0]         cmd,
    input  logic [HOST_AW-1:0] addr,
    input  logic [HOST_DW-1:0] data,
    input  logic [BE_W-1:0]    be,
    output logic [BANKS-1:0]   wps_n,
    output logic [HALF_W-1:0]  d,
    output logic [BW_HALF-1:0] bw_n,
    output logic [DEV_AW-1:0]  slot_addr
);

    wr_req_t w1, w2;

    // Each half of the word has its own lane of data and byte-write bits
    logic [1:0][HALF_W-1:0]  half_d;
    logic [1:0][BW_HALF-1:0] half_bw;

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign half_d[h]  = (h == 0) ? w1.data[h*HALF_W +: HALF_W]   : w2.data[h*HALF_W +: HALF_W];
        assign half_bw[h] = (h == 0) ? ~w1.be[h*BW_HALF +: BW_HALF]  : ~w2.be[h*BW_HALF +: BW_HALF];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w1    <= '0;
            w2    <= '0;
            wps_n <= '1;
            d     <= '0;
            bw_n  <= '1;
        end else if (!ph) begin
            w1.vld  <= wants_wr(cmd);
            w1.bank <= addr[HOST_AW-1 -: BANK_W];
            w1.addr <= addr[DEV_AW-1:0];
            w1.data <= data;
            w1.be   <= be;
            w2      <= w1;
            wps_n   <= sel_n(w1.vld, w1.bank);
            d       <= half_d[0];
            bw_n    <= half_bw[0];
        end else begin
            d    <= half_d[1];
            bw_n <= half_bw[1];
        end
    end

    assign slot_addr = w2.addr;

    // R7
    wps_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~wps_n) <= 1);

    // R3
    wps_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((wps_n != '1) && ph) |=> $stable(wps_n));

    // R2
    wps_align_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(wps_n) |-> ph);

endmodule

// File: rtl/qdr_rd_seq.sv
module qdr_rd_seq
    import qdr_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ph,
    input  logic [1:0]         cmd,
    input  logic [HOST_AW-1:0] addr,
    input  logic [HALF_W-1:0]  q,
    output logic [BANKS-1:0]   rps_n,
    output logic [DEV_AW-1:0]  slot_addr,
    output logic [HOST_DW-1:0] rdata,
    output logic               ready
);

    rd_req_t r1, r2;
    logic    v3, v4;
    logic [1:0][HALF_W-1:0] cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            r1    <= '0;
            r2    <= '0;
            v3    <= 1'b0;
            v4    <= 1'b0;
            rps_n <= '1;
            cap   <= '0;
            rdata <= '0;
            ready <= 1'b0;
        end else if (!ph) begin
            r1.vld  <= wants_rd(cmd);
            r1.bank <= addr[HOST_AW-1 -: BANK_W];
            r1.addr <= addr[DEV_AW-1:0];
            r2      <= r1;
            rps_n   <= sel_n(r2.vld, r2.bank);
            v3      <= r2.vld;
            v4      <= v3;
            cap[0]  <= q;
            rdata   <= cap;
            ready   <= v4;
        end else begin
            cap[1] <= q;
        end
    end

    assign slot_addr = r2.addr;

    // R7
    rps_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~rps_n) <= 1);

    // R2
    rps_align_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rps_n) |-> ph);

    // R6
    rdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |=> ready);

endmodule

// File: rtl/qdr_bank_ctl.sv
module qdr_bank_ctl
    import qdr_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cmd,
    input  logic [HOST_AW-1:0] rd_addr,
    input  logic [HOST_AW-1:0] wr_addr,
    input  logic [HOST_DW-1:0] wr_data,
    input  logic [BE_W-1:0]    wr_be,
    output logic [HOST_DW-1:0] rd_data,
    output logic               rd_ready,
    output logic [DEV_AW-1:0]  sram_addr,
    output logic [HALF_W-1:0]  sram_d,
    output logic [BW_HALF-1:0] sram_bw_n,
    output logic [BANKS-1:0]   sram_wps_n,
    output logic [BANKS-1:0]   sram_rps_n,
    input  logic [HALF_W-1:0]  sram_q
);

    logic              ph;
    logic [DEV_AW-1:0] wr_slot_addr;
    logic [DEV_AW-1:0] rd_slot_addr;

    // Phase 0 = host sampling edge; reset leaves the next edge at phase 0
    always_ff @(posedge clk) begin
        if (rst) ph <= 1'b0;
        else     ph <= ~ph;
    end

    qdr_wr_seq u_wr (
        .clk       (clk),
        .rst       (rst),
        .ph        (ph),
        .cmd       (cmd),
        .addr      (wr_addr),
        .data      (wr_data),
        .be        (wr_be),
        .wps_n     (sram_wps_n),
        .d         (sram_d),
        .bw_n      (sram_bw_n),
        .slot_addr (wr_slot_addr)
    );

    qdr_rd_seq u_rd (
        .clk       (clk),
        .rst       (rst),
        .ph        (ph),
        .cmd       (cmd),
        .addr      (rd_addr),
        .q         (sram_q),
        .rps_n     (sram_rps_n),
        .slot_addr (rd_slot_addr),
        .rdata     (rd_data),
        .ready     (rd_ready)
    );

    // Shared address bus: read addresses on even halves, write addresses on odd
    always_ff @(posedge clk) begin
        if (rst)      sram_addr <= '0;
        else if (!ph) sram_addr <= rd_slot_addr;
        else          sram_addr <= wr_slot_addr;
    end

    // R8
    rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        ((sram_rps_n != '1) && (sram_wps_n != '1)) |-> $countones(~sram_rps_n) == 1);

endmodule

// File: tb/sim_qdr_bank_ctl.sv
`timescale 1ns/1ps
module sim_qdr_bank_ctl;

    localparam int N = 176;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cmd;
    logic [19:0] rd_addr, wr_addr;
    logic [35:0] wr_data;
    logic [3:0]  wr_be;
    logic [35:0] rd_data;
    logic        rd_ready;
    logic [17:0] sram_addr, sram_d, sram_q;
    logic [1:0]  sram_bw_n;
    logic [3:0]  sram_wps_n, sram_rps_n;

    always #2 clk = ~clk;

    qdr_bank_ctl u0 (
        .clk(clk), .rst(rst), .cmd(cmd), .rd_addr(rd_addr), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .rd_data(rd_data), .rd_ready(rd_ready),
        .sram_addr(sram_addr), .sram_d(sram_d), .sram_bw_n(sram_bw_n),
        .sram_wps_n(sram_wps_n), .sram_rps_n(sram_rps_n), .sram_q(sram_q)
    );

    int nchk = 0, nerr = 0;
    bit done = 0;

    logic [1:0]  s_cmd [N];
    logic [19:0] s_ra [N], s_wa [N];
    logic [35:0] s_wd [N], s_exp [N];
    logic [3:0]  s_be [N];

    logic [35:0] rref [int];
    logic [35:0] mm [int];
    logic [17:0] qv [8];
    bit          qf [8];

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] addr_of(input int k);
        return {2'(k % 4), 18'(32'h2A5A0 + k * 37)};
    endfunction

    function automatic logic [35:0] dat(input int i);
        return {18'(i * 7919 + 5), 18'((i * 3571) ^ 32'h2AAAA)};
    endfunction

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw, input logic [3:0] be);
        logic [35:0] r;
        r = old;
        for (int j = 0; j < 4; j++) if (be[j]) r[j*9 +: 9] = nw[j*9 +: 9];
        return r;
    endfunction

    function automatic int first_low(input logic [3:0] s);
        for (int b = 0; b < 4; b++) if (!s[b]) return b;
        return -1;
    endfunction

    task automatic drive_slot(input int n);
        if (n < N) begin
            cmd = s_cmd[n]; rd_addr = s_ra[n]; wr_addr = s_wa[n];
            wr_data = s_wd[n]; wr_be = s_be[n];
        end else begin
            cmd = 2'b00;
        end
    endtask

    // Build stimulus and expected read words in slot order
    initial begin
        for (int i = 0; i < N; i++) begin
            s_cmd[i] = 2'b00; s_ra[i] = '0; s_wa[i] = '0; s_wd[i] = '0; s_be[i] = '0; s_exp[i] = '0;
            if (i < 16) begin
                s_cmd[i] = 2'b10; s_wa[i] = addr_of(i); s_be[i] = 4'hF; s_wd[i] = dat(i);
            end else if (i < 80) begin
                s_cmd[i] = 2'b10; s_wa[i] = addr_of(((i - 16) * 5) % 16);
                s_be[i] = 4'((i - 16) % 16); s_wd[i] = dat(i + 1000);
            end else if (i < 96) begin
                s_cmd[i] = 2'b01; s_ra[i] = addr_of(i - 80);
            end else if (i < 128) begin
                s_cmd[i] = 2'b11; s_wa[i] = addr_of(i % 16);
                s_ra[i] = (i % 2 == 0) ? addr_of(i % 16) : addr_of((i + 3) % 16);
                s_wd[i] = dat(i + 2000); s_be[i] = (i % 3 == 0) ? 4'h5 : 4'hF;
            end else if (i < 160) begin
                s_cmd[i] = 2'(i % 4); s_ra[i] = addr_of((i * 7) % 16);
                s_wa[i] = addr_of((i * 11) % 16); s_wd[i] = dat(i + 3000); s_be[i] = 4'(i * 3);
            end
            if (s_cmd[i][1]) begin
                logic [35:0] o;
                o = rref.exists(int'(s_wa[i])) ? rref[int'(s_wa[i])] : 36'h0;
                rref[int'(s_wa[i])] = merge(o, s_wd[i], s_be[i]);
            end
            if (s_cmd[i][0])
                s_exp[i] = rref.exists(int'(s_ra[i])) ? rref[int'(s_ra[i])] : 36'h0;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int pb;
        bit pend;
        logic [17:0] plo;
        logic [1:0]  pbw;
        pend = 0; pb = 0; plo = '0; pbw = '1;
        for (int k = 0; k < 8; k++) begin qf[k] = 0; qv[k] = '0; end
        rst = 1'b1; cmd = 2'b00; rd_addr = '0; wr_addr = '0; wr_data = '0; wr_be = '0; sram_q = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(sram_wps_n == 4'hF, "R1 wps", 36'(sram_wps_n), 36'hF);
        chk(sram_rps_n == 4'hF, "R1 rps", 36'(sram_rps_n), 36'hF);
        chk(rd_ready == 1'b0, "R1 rd_ready", 36'(rd_ready), 36'h0);
        rst = 1'b0;
        drive_slot(0);
        for (int c = 1; c <= 2 * N + 12; c++) begin
            int e;
            logic [3:0] ew, er;
            @(posedge clk);
            @(negedge clk);
            e = c - 1;

            // Bench device model: acts only on what appears on the buses
            if (e % 2 == 0 && first_low(sram_wps_n) >= 0) begin
                pb = first_low(sram_wps_n); plo = sram_d; pbw = sram_bw_n; pend = 1;
            end else if (e % 2 == 1 && pend) begin
                int key;
                logic [35:0] o;
                key = (pb << 18) | int'(sram_addr);
                o = mm.exists(key) ? mm[key] : 36'h0;
                for (int j = 0; j < 2; j++) begin
                    if (!pbw[j])       o[j*9 +: 9]      = plo[j*9 +: 9];
                    if (!sram_bw_n[j]) o[18 + j*9 +: 9] = sram_d[j*9 +: 9];
                end
                mm[key] = o;
                pend = 0;
            end
            if (e % 2 == 0 && first_low(sram_rps_n) >= 0) begin
                int key;
                logic [35:0] v;
                key = (first_low(sram_rps_n) << 18) | int'(sram_addr);
                v = mm.exists(key) ? mm[key] : 36'h0;
                qv[(e + 1) % 8] = v[17:0];  qf[(e + 1) % 8] = 1;
                qv[(e + 2) % 8] = v[35:18]; qf[(e + 2) % 8] = 1;
            end
            if (qf[e % 8]) begin sram_q = qv[e % 8]; qf[e % 8] = 0; end
            else sram_q = '0;

            // Write side (R3 R4 R7 R9)
            ew = 4'hF;
            if (e >= 2) begin
                int nw;
                nw = (e - 2) / 2;
                if (nw < N && s_cmd[nw][1]) begin
                    ew[s_wa[nw][19:18]] = 1'b0;
                    if (e % 2 == 0) begin
                        chk(sram_d == s_wd[nw][17:0], "R3 lower half", 36'(sram_d), 36'(s_wd[nw][17:0]));
                        chk(sram_bw_n == ~s_be[nw][1:0], "R9 lower byte writes", 36'(sram_bw_n), 36'(~s_be[nw][1:0]));
                    end else begin
                        chk(sram_d == s_wd[nw][35:18], "R3 upper half", 36'(sram_d), 36'(s_wd[nw][35:18]));
                        chk(sram_bw_n == ~s_be[nw][3:2], "R9 upper byte writes", 36'(sram_bw_n), 36'(~s_be[nw][3:2]));
                        chk(sram_addr == s_wa[nw][17:0], "R4 write address", 36'(sram_addr), 36'(s_wa[nw][17:0]));
                    end
                end
            end
            chk(sram_wps_n == ew, "R7 write select", 36'(sram_wps_n), 36'(ew));

            // Read side (R5 R7 R8)
            er = 4'hF;
            if (e >= 4) begin
                int nr;
                nr = (e - 4) / 2;
                if (nr < N && s_cmd[nr][0]) begin
                    er[s_ra[nr][19:18]] = 1'b0;
                    if (e % 2 == 0)
                        chk(sram_addr == s_ra[nr][17:0], "R5 read address", 36'(sram_addr), 36'(s_ra[nr][17:0]));
                end
            end
            chk(sram_rps_n == er, "R7 read select", 36'(sram_rps_n), 36'(er));

            // Host return (R6 R8 R9 R2)
            if (e >= 8 && (e - 8) / 2 < N && s_cmd[(e - 8) / 2][0]) begin
                chk(rd_ready == 1'b1, "R6 rd_ready", 36'(rd_ready), 36'h1);
                chk(rd_data == s_exp[(e - 8) / 2], "R6 R8 R9 read word", rd_data, s_exp[(e - 8) / 2]);
            end else begin
                chk(rd_ready == 1'b0, "R2 rd_ready idle", 36'(rd_ready), 36'h0);
            end

            if (c % 2 == 0) drive_slot(c / 2);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule